// File: doc/BRIEF.md
# Processor Fault and Trap Sequencer

This block is the control sequencer that a 32-bit core consults when something goes wrong or when an instruction asks for a trap. It watches five event lines: bus error, odd-address instruction fetch, divide by zero, unconditional trap and conditional trap. It also watches the core's context flags, which are the instruction-boundary flag and the return-from-exception reload flag. From these it chooses whether to start exception entry or to stop the core for good. When it starts an entry it presents a vector number, the vector's table offset and a stack-frame format code to the stacking unit, together with a one-cycle valid strobe.

The block owns the supervisor bit and the two trace bits of the status register, and it holds a saved copy of those bits that is restored when the handler returns. If a trap is taken while tracing is on, the block remembers a deferred trace. On the handler's return it raises that trace as a fresh exception, so the trace belongs to the trapping instruction and not to the handler. A fault that arrives while a fault frame or a reset is being processed stops the core. The same happens for a bus error while state is being reloaded from the stack. In that halted state nothing is written, and only a synchronous reset brings the core back.

Top module: `fault_seq`

## Requirements
- R1: Reset takes effect on the clock edge where rst is high. After it the sequencer is in reset-exception processing: busy_o=1, sup_o=1, t1_o=t0_o=0, halted_o=0, tpend_o=0, fmt_vld_o=0 and vec_o=0. A stack_done_i pulse ends this processing, and busy_o reads 0 after the next edge.
- R2: A bus error in the run state starts entry with vector 2. The format code is 0xA when at_bound_i=1 and 0xB when at_bound_i=0. fmt_vld_o is high for exactly the one cycle that follows the sampling edge, and vec_off_o always equals vec_o*4.
- R3: An odd instruction fetch (odd_fetch_i) starts entry at once with vector 3. It uses the same 0xA/0xB format rule as a bus error.
- R4: divz_i traps with vector 5. trap_i traps with the vector given on trap_vec_i. ctrap_i traps with trap_vec_i only when cond_i=1, and with cond_i=0 it changes no output. Every trap frame uses format code 0x0.
- R5: When several events arrive in one cycle, the priority is bus error > odd fetch > divide by zero > trap > conditional trap.
- R6: The core halts (halted_o=1) on a bus error or odd fetch during reset processing, and on either of them during a bus or address fault entry. It also halts on a bus error while rte_reload_i=1. The halt stays set until rst.
- R7: While halted the block gives no format strobe, holds busy_o=0 and ignores every event.
- R8: Each entry from the run state saves {S,T1,T0}, then sets S and clears T1 and T0. A later rte_done_i in the run state restores the saved bits.
- R9: A trap taken with T1 or T0 set raises tpend_o. At the next rte_done_i the saved bits are restored, and a trace entry with vector 9 and format 0x2 starts at once. tpend_o clears in that same step.
- R10: A bus error or odd fetch during a trap or trace entry does not halt. It restarts the entry as a fault entry with a new strobe.
- R11: sr_wr_i loads sr_wdata_i as {S,T1,T0} only in the run state when no event is taken. It has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_err_i | input | 1 | Bus error reported by the bus unit |
| odd_fetch_i | input | 1 | Instruction fetch at odd address |
| divz_i | input | 1 | Divide with zero divisor |
| trap_i | input | 1 | Unconditional trap instruction |
| ctrap_i | input | 1 | Conditional/overflow/bounds trap instruction |
| cond_i | input | 1 | Condition of the conditional trap is met |
| trap_vec_i | input | VEC_W | Vector number for trap_i and ctrap_i |
| at_bound_i | input | 1 | Core sits at an instruction boundary |
| rte_reload_i | input | 1 | Core is reloading state during a return |
| rte_done_i | input | 1 | Handler return has completed |
| stack_done_i | input | 1 | Stacking unit finished the current entry |
| sr_wr_i | input | 1 | Write the status bits |
| sr_wdata_i | input | 3 | New {S,T1,T0} |
| vec_o | output | VEC_W | Vector number of current entry |
| vec_off_o | output | VEC_W+2 | Vector table offset (vec_o*4) |
| fmt_o | output | FMT_W | Stack frame format code |
| fmt_vld_o | output | 1 | One-cycle strobe for a new frame |
| busy_o | output | 1 | Exception processing in progress |
| sup_o | output | 1 | Supervisor bit |
| t1_o | output | 1 | Trace bit T1 |
| t0_o | output | 1 | Trace bit T0 |
| tpend_o | output | 1 | Deferred trace waiting for the return |
| halted_o | output | 1 | Halted after a double fault |

## Verification
Two functions can meet in one cycle. The first is priority selection among simultaneous events. The second is fault escalation on top of an entry already in progress. Random cycles raise any mix of bus error, odd fetch and the three trap kinds together. The strobed vector and format are compared with a bench model of the priority rule and the boundary-dependent format. Directed sequences inject a fault during the reset step, during a fault entry and during a trap entry. The bench then checks that only the first two halt, and that the third yields a fresh fault strobe.

// File: rtl/fault_seq_pkg.sv
package fault_seq_pkg;
  typedef enum logic [1:0] {
    ST_RSTX = 2'd0,
    ST_RUN  = 2'd1,
    ST_EXC  = 2'd2,
    ST_HALT = 2'd3
  } seq_st_e;

  localparam int VEC_BUS   = 2;
  localparam int VEC_ADDR  = 3;
  localparam int VEC_DIVZ  = 5;
  localparam int VEC_TRACE = 9;

  localparam logic [3:0] FMT_SHORT = 4'hA;
  localparam logic [3:0] FMT_LONG  = 4'hB;
  localparam logic [3:0] FMT_TRAP  = 4'h0;
  localparam logic [3:0] FMT_TRACE = 4'h2;
endpackage

// File: rtl/fault_prio.sv
module fault_prio
  import fault_seq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             bus_i,
  input  logic             odd_i,
  input  logic             divz_i,
  input  logic             trap_i,
  input  logic             ctrap_i,
  input  logic             cond_i,
  input  logic [VEC_W-1:0] tvec_i,
  output logic             take_o,
  output logic             fault_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int NREQ = 5;

  logic [NREQ-1:0] req;
  logic [VEC_W-1:0] vtab [NREQ];

  // index order is priority order: highest index wins
  assign req = {bus_i, odd_i, divz_i, trap_i, ctrap_i & cond_i};

  assign vtab[4] = VEC_W'(VEC_BUS);
  assign vtab[3] = VEC_W'(VEC_ADDR);
  assign vtab[2] = VEC_W'(VEC_DIVZ);
  assign vtab[1] = tvec_i;
  assign vtab[0] = tvec_i;

  always_comb begin
    take_o = 1'b0;
    vec_o  = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (req[i]) begin
        take_o = 1'b1;
        vec_o  = vtab[i];
      end
    end
  end

  assign fault_o = bus_i | odd_i;
endmodule

// File: rtl/fault_fmt.sv
module fault_fmt
  import fault_seq_pkg::*;
#(
  parameter int FMT_W = 4
) (
  input  logic             fault_i,
  input  logic             bound_i,
  output logic [FMT_W-1:0] fmt_o
);
  always_comb begin
    if (fault_i) fmt_o = bound_i ? FMT_W'(FMT_SHORT) : FMT_W'(FMT_LONG);
    else         fmt_o = FMT_W'(FMT_TRAP);
  end
endmodule

// File: rtl/fault_sr.sv
module fault_sr (
  input  logic       clk,
  input  logic       rst,
  input  logic       enter_i,
  input  logic       trap_i,
  input  logic       trace_i,
  input  logic       restore_i,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  output logic       sup_o,
  output logic [1:0] t_o,
  output logic       tpend_o
);
  logic [2:0] copy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_o   <= 1'b1;
      t_o     <= 2'b00;
      copy_q  <= 3'b100;
      tpend_o <= 1'b0;
    end else if (enter_i) begin
      copy_q <= {sup_o, t_o};
      sup_o  <= 1'b1;
      t_o    <= 2'b00;
      if (trap_i && (t_o != 2'b00)) tpend_o <= 1'b1;
    end else if (trace_i) begin
      // returning handler restores, then trace entry overlays at once;
      // the saved copy already holds the restored bits
      sup_o   <= 1'b1;
      t_o     <= 2'b00;
      tpend_o <= 1'b0;
    end else if (restore_i) begin
      {sup_o, t_o} <= copy_q;
    end else if (wr_i) begin
      {sup_o, t_o} <= wdata_i;
    end
  end

  // R9: a deferred trace only appears from a trap entry with tracing on
  a_r9_pend_src: assert property (@(posedge clk) disable iff (rst)
    $rose(tpend_o) |-> $past(enter_i && trap_i));
endmodule

// File: rtl/fault_seq.sv
module fault_seq
  import fault_seq_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int FMT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_err_i,
  input  logic               odd_fetch_i,
  input  logic               divz_i,
  input  logic               trap_i,
  input  logic               ctrap_i,
  input  logic               cond_i,
  input  logic [VEC_W-1:0]   trap_vec_i,
  input  logic               at_bound_i,
  input  logic               rte_reload_i,
  input  logic               rte_done_i,
  input  logic               stack_done_i,
  input  logic               sr_wr_i,
  input  logic [2:0]         sr_wdata_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic [VEC_W+1:0]   vec_off_o,
  output logic [FMT_W-1:0]   fmt_o,
  output logic               fmt_vld_o,
  output logic               busy_o,
  output logic               sup_o,
  output logic               t1_o,
  output logic               t0_o,
  output logic               tpend_o,
  output logic               halted_o
);
  seq_st_e          st_q;
  logic             exc_fault_q;
  logic             ev_take, ev_fault;
  logic [VEC_W-1:0] ev_vec;
  logic [FMT_W-1:0] ev_fmt;
  logic [1:0]       t_bits;
  logic             in_run, dbl_run, run_take, run_ret;
  logic             sr_enter, sr_trace, sr_restore, sr_wr;

  fault_prio #(.VEC_W(VEC_W)) u_prio (
    .bus_i   (bus_err_i),
    .odd_i   (odd_fetch_i),
    .divz_i  (divz_i),
    .trap_i  (trap_i),
    .ctrap_i (ctrap_i),
    .cond_i  (cond_i),
    .tvec_i  (trap_vec_i),
    .take_o  (ev_take),
    .fault_o (ev_fault),
    .vec_o   (ev_vec)
  );

  fault_fmt #(.FMT_W(FMT_W)) u_fmt (
    .fault_i (ev_fault),
    .bound_i (at_bound_i),
    .fmt_o   (ev_fmt)
  );

  assign in_run     = (st_q == ST_RUN);
  assign dbl_run    = in_run && bus_err_i && rte_reload_i;
  assign run_take   = in_run && !dbl_run && ev_take;
  assign run_ret    = in_run && !dbl_run && !ev_take && rte_done_i;
  assign sr_enter   = run_take;
  assign sr_trace   = run_ret && tpend_o;
  assign sr_restore = run_ret && !tpend_o;
  assign sr_wr      = in_run && !dbl_run && !ev_take && sr_wr_i;

  fault_sr u_sr (
    .clk       (clk),
    .rst       (rst),
    .enter_i   (sr_enter),
    .trap_i    (!ev_fault),
    .trace_i   (sr_trace),
    .restore_i (sr_restore),
    .wr_i      (sr_wr),
    .wdata_i   (sr_wdata_i),
    .sup_o     (sup_o),
    .t_o       (t_bits),
    .tpend_o   (tpend_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_RSTX;
      vec_o       <= '0;
      fmt_o       <= '0;
      fmt_vld_o   <= 1'b0;
      exc_fault_q <= 1'b0;
    end else begin
      fmt_vld_o <= 1'b0;
      unique case (st_q)
        ST_RSTX: begin
          if (ev_fault)          st_q <= ST_HALT;
          else if (stack_done_i) st_q <= ST_RUN;
        end
        ST_RUN: begin
          if (dbl_run) begin
            st_q <= ST_HALT;
          end else if (ev_take) begin
            st_q        <= ST_EXC;
            vec_o       <= ev_vec;
            fmt_o       <= ev_fmt;
            fmt_vld_o   <= 1'b1;
            exc_fault_q <= ev_fault;
          end else if (rte_done_i && tpend_o) begin
            st_q        <= ST_EXC;
            vec_o       <= VEC_W'(VEC_TRACE);
            fmt_o       <= FMT_W'(FMT_TRACE);
            fmt_vld_o   <= 1'b1;
            exc_fault_q <= 1'b0;
          end
        end
        ST_EXC: begin
          if (ev_fault && exc_fault_q) begin
            st_q <= ST_HALT;
          end else if (ev_fault) begin
            vec_o       <= ev_vec;
            fmt_o       <= ev_fmt;
            fmt_vld_o   <= 1'b1;
            exc_fault_q <= 1'b1;
          end else if (stack_done_i) begin
            st_q <= ST_RUN;
          end
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  assign vec_off_o = {vec_o, 2'b00};
  assign busy_o    = (st_q == ST_RSTX) || (st_q == ST_EXC);
  assign halted_o  = (st_q == ST_HALT);
  assign t1_o      = t_bits[1];
  assign t0_o      = t_bits[0];

  // R6: the halt is sticky
  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> halted_o);

  // R7: a halted core issues no frame and is not busy
  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> (!fmt_vld_o && !busy_o));

  // R8: every strobed entry runs in supervisor mode with tracing off
  a_r8_entry_sr: assert property (@(posedge clk) disable iff (rst)
    fmt_vld_o |-> (sup_o && !t1_o && !t0_o));

  // R2: fault vectors always carry a short or long fault frame
  a_r2_fault_fmt: assert property (@(posedge clk) disable iff (rst)
    (fmt_vld_o && (vec_o == VEC_W'(VEC_BUS) || vec_o == VEC_W'(VEC_ADDR)))
      |-> (fmt_o == FMT_W'(FMT_SHORT) || fmt_o == FMT_W'(FMT_LONG)));
endmodule

// File: tb/tb_fault_seq.sv
module tb_fault_seq;
  localparam int VEC_W = 8;
  localparam int FMT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_err_i = 0, odd_fetch_i = 0, divz_i = 0, trap_i = 0, ctrap_i = 0, cond_i = 0;
  logic [VEC_W-1:0] trap_vec_i = '0;
  logic at_bound_i = 0, rte_reload_i = 0, rte_done_i = 0, stack_done_i = 0, sr_wr_i = 0;
  logic [2:0] sr_wdata_i = '0;
  logic [VEC_W-1:0] vec_o;
  logic [VEC_W+1:0] vec_off_o;
  logic [FMT_W-1:0] fmt_o;
  logic fmt_vld_o, busy_o, sup_o, t1_o, t0_o, tpend_o, halted_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fault_seq #(.VEC_W(VEC_W), .FMT_W(FMT_W)) dut (
    .clk(clk), .rst(rst), .bus_err_i(bus_err_i), .odd_fetch_i(odd_fetch_i),
    .divz_i(divz_i), .trap_i(trap_i), .ctrap_i(ctrap_i), .cond_i(cond_i),
    .trap_vec_i(trap_vec_i), .at_bound_i(at_bound_i), .rte_reload_i(rte_reload_i),
    .rte_done_i(rte_done_i), .stack_done_i(stack_done_i), .sr_wr_i(sr_wr_i),
    .sr_wdata_i(sr_wdata_i), .vec_o(vec_o), .vec_off_o(vec_off_o), .fmt_o(fmt_o),
    .fmt_vld_o(fmt_vld_o), .busy_o(busy_o), .sup_o(sup_o), .t1_o(t1_o), .t0_o(t0_o),
    .tpend_o(tpend_o), .halted_o(halted_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    bus_err_i = 0; odd_fetch_i = 0; divz_i = 0; trap_i = 0; ctrap_i = 0; cond_i = 0;
    rte_reload_i = 0; rte_done_i = 0; stack_done_i = 0; sr_wr_i = 0;
  endtask

  task automatic do_reset();
    idle();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic to_run();
    stack_done_i = 1; tick(); stack_done_i = 0;
  endtask

  // expected {take, fault, vec, fmt} from the priority and format rules
  function automatic logic [13:0] model(input logic b, input logic o, input logic d,
      input logic t, input logic c, input logic cd, input logic [7:0] tv, input logic bd);
    logic [7:0] v; logic [3:0] f; logic tk; logic fl;
    tk = 1; fl = 0; v = 0; f = 4'h0;
    if (b)            begin v = 8'd2; fl = 1; end
    else if (o)       begin v = 8'd3; fl = 1; end
    else if (d)       v = 8'd5;
    else if (t)       v = tv;
    else if (c && cd) v = tv;
    else              tk = 0;
    if (fl) f = bd ? 4'hA : 4'hB;
    return {tk, fl, v, f};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20517));

    // R1 reset state
    do_reset();
    chk("R1 busy", busy_o, 1); chk("R1 sup", sup_o, 1);
    chk("R1 trace", {t1_o, t0_o}, 0); chk("R1 halted", halted_o, 0);
    chk("R1 tpend", tpend_o, 0); chk("R1 vld", fmt_vld_o, 0); chk("R1 vec", vec_o, 0);
    to_run();
    chk("R1 leave", busy_o, 0);

    // R4 conditional trap with cond low has no effect
    ctrap_i = 1; cond_i = 0; trap_vec_i = 8'd40; tick(); idle();
    chk("R4 cond0 vld", fmt_vld_o, 0); chk("R4 cond0 busy", busy_o, 0);

    // random mix: R2 R3 R4 R5 R8 R9
    for (int n = 0; n < 60; n++) begin
      logic [1:0] tb; logic [13:0] e; logic b, o, d, t, c, cd, bd; logic [7:0] tv;
      tb = 2'($urandom);
      sr_wr_i = 1; sr_wdata_i = {1'b1, tb}; tick(); sr_wr_i = 0;
      b = ($urandom % 5) == 0; o = ($urandom % 4) == 0; d = ($urandom % 4) == 0;
      t = ($urandom % 4) == 0; c = ($urandom % 3) == 0; cd = 1'($urandom);
      bd = 1'($urandom); tv = 8'(32 + ($urandom % 200));
      e = model(b, o, d, t, c, cd, tv, bd);
      bus_err_i = b; odd_fetch_i = o; divz_i = d; trap_i = t; ctrap_i = c; cond_i = cd;
      trap_vec_i = tv; at_bound_i = bd;
      tick(); idle();
      if (e[13]) begin
        chk("R5 vld", fmt_vld_o, 1);
        chk("R5 vec", vec_o, e[11:4]);
        chk("R2 R3 R4 fmt", fmt_o, e[3:0]);
        chk("R2 off", vec_off_o, {e[11:4], 2'b00});
        chk("R8 entry", {sup_o, t1_o, t0_o}, 3'b100);
        chk("R9 pend", tpend_o, (!e[12] && tb != 0));
        tick();
        chk("R2 one-cycle", fmt_vld_o, 0);
        to_run();
        rte_done_i = 1; tick(); rte_done_i = 0;
        if (!e[12] && tb != 0) begin
          chk("R9 trace vld", fmt_vld_o, 1); chk("R9 trace vec", vec_o, 9);
          chk("R9 trace fmt", fmt_o, 4'h2); chk("R9 cleared", tpend_o, 0);
          to_run();
          rte_done_i = 1; tick(); rte_done_i = 0;
        end
        chk("R8 restore", {sup_o, t1_o, t0_o}, {1'b1, tb});
      end else begin
        chk("R4 none", fmt_vld_o, 0);
        chk("R4 none sr", {sup_o, t1_o, t0_o}, {1'b1, tb});
      end
    end

    // R11 status write ignored while busy
    trap_i = 1; trap_vec_i = 8'd33; tick(); idle();
    sr_wr_i = 1; sr_wdata_i = 3'b011; tick(); sr_wr_i = 0;
    to_run();
    chk("R11 ignored", {sup_o, t1_o, t0_o}, 3'b100);

    // R10 fault during trap entry restarts as fault entry
    trap_i = 1; tick(); idle();
    bus_err_i = 1; at_bound_i = 0; tick(); idle();
    chk("R10 vld", fmt_vld_o, 1); chk("R10 vec", vec_o, 2);
    chk("R10 fmt", fmt_o, 4'hB); chk("R10 nohalt", halted_o, 0);

    // R6 fault during fault entry halts
    odd_fetch_i = 1; tick(); idle();
    chk("R6 dbl entry", halted_o, 1);
    // R7 ignores everything while halted
    trap_i = 1; bus_err_i = 1; stack_done_i = 1; tick(); idle(); tick();
    chk("R7 halt vld", fmt_vld_o, 0); chk("R7 halt busy", busy_o, 0);
    chk("R6 sticky", halted_o, 1);

    // R6 fault during reset processing
    do_reset();
    bus_err_i = 1; tick(); idle();
    chk("R6 reset dbl", halted_o, 1);
    do_reset();
    chk("R1 rst clears halt", halted_o, 0);
    to_run();

    // R6 bus error during state reload
    rte_reload_i = 1; bus_err_i = 1; tick(); idle();
    chk("R6 reload dbl", halted_o, 1); chk("R6 reload vld", fmt_vld_o, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule